// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a host that issues single read or write requests and an external asynchronous static memory (SRAM or PSRAM). It converts each request into one bus cycle on a 26-bit address bus and a 16-bit bidirectional data bus. The cycle is framed by an active-low chip select, output enable, write enable and a pair of active-low byte-lane enables. Every memory-side output changes only on the host clock, and the host clock is never sent to the memory.

A cycle has an address-setup phase and then a data phase. Each phase length is a whole number of host clocks and comes from static timing inputs. A read timing set is always present. When the extended-mode input is high, writes use a second, separate timing set. Read data is sampled on the same clock edge that ends the data phase, so output enable rises after the sample. This meets a memory data-hold time of zero.

The host raises `req_valid` and holds the request steady until `req_ready` pulses for one clock. For reads, `rsp_rdata` carries the returned word during that pulse. Chip select is high during the pulse, so two back-to-back transactions always have a gap between them.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip select, output enable, write enable and both byte-lane enables are high, and `req_ready` is low.
- R2: A read holds chip select low for exactly S + D' clocks. S is the selected setup count (0..15) and D' is the selected data-phase count, with 0 counted as 1. Output enable is low for those same clocks.
- R3: During a read, write enable stays high and both byte-lane enables stay low in every clock. This holds whatever host byte enables are supplied.
- R4: The word that the memory presents during the data phase of a read appears on `rsp_rdata` while `req_ready` is high. The word is sampled on the clock edge at which output enable is released.
- R5: A write holds chip select low for S + D' + 1 clocks. Write enable is low for exactly D' clocks, and output enable stays high. The data bus is driven from the first setup clock until one clock after write enable rises.
- R6: During a write, byte-lane enable bit k equals the inverse of host byte enable bit k (bit 0 covers data bits 7:0). Only the enabled bytes of the memory word change.
- R7: When `ext_mode` is 1, writes take their counts from `wr_setup` and `wr_dphase`. Otherwise writes use `rd_setup` and `rd_dphase`. Reads always use the read counts.
- R8: A setup count of 0 gives no setup phase. A data-phase count of 0 gives a one-clock data phase.
- R9: `req_ready` is high for exactly one clock per transaction. Chip select is high in that clock and stays high for at least one clock between transactions.
- R10: The controller drives the data bus only during write cycles. At all other times it releases the bus, so the memory can return read data without conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Memory address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for writes (bit 0 = low byte) |
| ext_mode | input | 1 | Use separate write timing set |
| rd_setup | input | 4 | Setup count for reads (and for writes when not extended) |
| rd_dphase | input | 8 | Data-phase count for reads (and for writes when not extended) |
| wr_setup | input | 4 | Setup count for writes in extended mode |
| wr_dphase | input | 8 | Data-phase count for writes in extended mode |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `req_ready` |
| mem_addr | output | 26 | Memory address bus |
| mem_dq | inout | 16 | Memory data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | 2 | Byte-lane enables, active low |

## Verification
The assertions assume that the host holds `req_valid` and the request fields steady from the time it raises `req_valid` until `req_ready` pulses. They also assume the timing inputs do not change while a transaction is in progress. The bench only changes these inputs on a falling clock edge while the controller is idle. It drops `req_valid` as soon as it sees the completion pulse. Random timing values span the full setup range, and directed cases cover a zero setup count, a zero data-phase count and the largest data-phase count.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    localparam int ADDR_W  = 26;
    localparam int DATA_W  = 16;
    localparam int LANES   = DATA_W / 8;
    localparam int SETUP_W = 4;
    localparam int DPH_W   = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_DATA,
        PH_HOLD,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [DPH_W-1:0]   dphase;
    } timing_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  be;
    } req_t;

    function automatic logic [DPH_W-1:0] dphase_len(input logic [DPH_W-1:0] f);
        return (f == '0) ? DPH_W'(1) : f;
    endfunction
endpackage

// File: rtl/sram_timing_sel.sv
module sram_timing_sel
    import sram_ctrl_pkg::*;
(
    input  logic    ext_mode,
    input  logic    is_write,
    input  timing_t rd_set,
    input  timing_t wr_set,
    output timing_t sel_set
);
    always_comb begin
        sel_set = (ext_mode && is_write) ? wr_set : rd_set;
    end
endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
    import sram_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    is_write,
    input  timing_t tset,
    output phase_e  phase,
    output logic    data_last
);
    logic [DPH_W-1:0] cnt;
    logic [DPH_W-1:0] dlen;
    logic             wr_q;

    assign data_last = (phase == PH_DATA) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            dlen  <= '0;
            wr_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        wr_q <= is_write;
                        dlen <= dphase_len(tset.dphase);
                        if (tset.setup != '0) begin
                            phase <= PH_SETUP;
                            cnt   <= DPH_W'(tset.setup) - DPH_W'(1);
                        end else begin
                            phase <= PH_DATA;
                            cnt   <= dphase_len(tset.dphase) - DPH_W'(1);
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_DATA;
                        cnt   <= dlen - DPH_W'(1);
                    end else begin
                        cnt <= cnt - DPH_W'(1);
                    end
                end
                PH_DATA: begin
                    if (cnt == '0) phase <= wr_q ? PH_HOLD : PH_GAP;
                    else           cnt   <= cnt - DPH_W'(1);
                end
                PH_HOLD: phase <= PH_GAP;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_DATA_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> (cnt < dlen)); // R2
    AST_HOLD_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD) |-> wr_q); // R5
    AST_GAP_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GAP) |=> (phase == PH_IDLE)); // R9
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [LANES-1:0]    req_be,
    input  logic                ext_mode,
    input  logic [SETUP_W-1:0]  rd_setup,
    input  logic [DPH_W-1:0]    rd_dphase,
    input  logic [SETUP_W-1:0]  wr_setup,
    input  logic [DPH_W-1:0]    wr_dphase,
    output logic                req_ready,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    inout  wire  [DATA_W-1:0]   mem_dq,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [LANES-1:0]    mem_bl_n
);
    timing_t          rd_set, wr_set, sel_set;
    phase_e           phase;
    logic             data_last;
    logic             start;
    logic             active;
    logic             drive;
    req_t             req_q;
    logic [DATA_W-1:0] rdata_q;

    assign rd_set = '{setup: rd_setup, dphase: rd_dphase};
    assign wr_set = '{setup: wr_setup, dphase: wr_dphase};

    sram_timing_sel u_sel (
        .ext_mode (ext_mode),
        .is_write (req_write),
        .rd_set   (rd_set),
        .wr_set   (wr_set),
        .sel_set  (sel_set)
    );

    assign start = req_valid && (phase == PH_IDLE);

    sram_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_write  (req_write),
        .tset      (sel_set),
        .phase     (phase),
        .data_last (data_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                req_q <= '{write: req_write, addr: req_addr, wdata: req_wdata, be: req_be};
            end
            if (data_last && !req_q.write) begin
                rdata_q <= mem_dq;
            end
        end
    end

    assign active    = (phase == PH_SETUP) || (phase == PH_DATA) || (phase == PH_HOLD);
    assign drive     = active && req_q.write;
    assign mem_ce_n  = !active;
    assign mem_oe_n  = !(active && !req_q.write);
    assign mem_we_n  = !((phase == PH_DATA) && req_q.write);
    assign mem_bl_n  = !active ? '1 : (req_q.write ? ~req_q.be : '0);
    assign mem_addr  = req_q.addr;
    assign mem_dq    = drive ? req_q.wdata : 'z;
    assign req_ready = (phase == PH_GAP);
    assign rsp_rdata = rdata_q;

    AST_CE_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |=> mem_ce_n); // R9
    AST_READY_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready); // R9
    AST_READY_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> mem_ce_n); // R9
    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n); // R3
    AST_READ_LANES_LOW: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_bl_n == '0)); // R3
    AST_WE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R5
    AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce_n && drive)); // R5
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !drive); // R10
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R2
endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;
    import sram_ctrl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic               req_valid = 1'b0, req_write = 1'b0, ext_mode = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic [LANES-1:0]   req_be = '0;
    logic [SETUP_W-1:0] rd_setup = '0, wr_setup = '0;
    logic [DPH_W-1:0]   rd_dphase = '0, wr_dphase = '0;
    logic               req_ready, mem_ce_n, mem_oe_n, mem_we_n;
    logic [DATA_W-1:0]  rsp_rdata;
    logic [ADDR_W-1:0]  mem_addr;
    logic [LANES-1:0]   mem_bl_n;
    wire  [DATA_W-1:0]  mem_dq;

    int vectors = 0;
    int fails = 0;

    logic [DATA_W-1:0] mem_arr [64];
    logic [DATA_W-1:0] shadow  [64];

    sram_async_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .ext_mode(ext_mode), .rd_setup(rd_setup), .rd_dphase(rd_dphase),
        .wr_setup(wr_setup), .wr_dphase(wr_dphase), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq(mem_dq),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bl_n(mem_bl_n)
    );

    // memory model
    assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem_arr[mem_addr[5:0]] : 'z;
    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) begin
            if (!mem_bl_n[0]) mem_arr[mem_addr[5:0]][7:0]  <= mem_dq[7:0];
            if (!mem_bl_n[1]) mem_arr[mem_addr[5:0]][15:8] <= mem_dq[15:8];
        end
    end

    function automatic int eff_d(input logic [DPH_W-1:0] d);
        return (d == 0) ? 1 : int'(d);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic txn(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                       input logic [LANES-1:0] be, input bit ext,
                       input int rs, input int rdp, input int ws, input int wdp);
        int ce = 0, oe = 0, we = 0, bad = 0, guard = 0;
        int s, d, exp_ce;
        bit seen = 0;
        logic [DATA_W-1:0] exp_rd;
        req_write = wr; req_addr = a; req_wdata = wd; req_be = be; ext_mode = ext;
        rd_setup = SETUP_W'(rs); rd_dphase = DPH_W'(rdp);
        wr_setup = SETUP_W'(ws); wr_dphase = DPH_W'(wdp);
        req_valid = 1'b1;
        s = (wr && ext) ? ws : rs;
        d = eff_d((wr && ext) ? DPH_W'(wdp) : DPH_W'(rdp));
        exp_ce = s + d + (wr ? 1 : 0);
        exp_rd = shadow[a[5:0]];
        while (!seen && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (req_ready) seen = 1;
            else begin
                if (!mem_ce_n) ce++;
                if (!mem_oe_n) oe++;
                if (!mem_we_n) we++;
                if (!mem_ce_n) begin
                    if (wr && mem_bl_n != ~be) bad++;
                    if (!wr && (mem_bl_n != 2'b00 || !mem_we_n)) bad++;
                end
            end
        end
        chk(seen, "R9 ready seen", int'(seen), 1);
        chk(ce == exp_ce, wr ? "R5 R7 R8 ce-low clocks" : "R2 R8 ce-low clocks", ce, exp_ce);
        chk(oe == (wr ? 0 : exp_ce), "R2 R5 oe-low clocks", oe, wr ? 0 : exp_ce);
        chk(we == (wr ? d : 0), "R5 R8 we-low clocks", we, wr ? d : 0);
        chk(bad == 0, wr ? "R6 lanes" : "R3 lanes/we", bad, 0);
        chk(mem_ce_n == 1'b1, "R9 ce high at ready", int'(mem_ce_n), 1);
        if (!wr) chk(rsp_rdata == exp_rd, "R4 R10 read data", int'(rsp_rdata), int'(exp_rd));
        else begin
            if (be[0]) shadow[a[5:0]][7:0]  = wd[7:0];
            if (be[1]) shadow[a[5:0]][15:8] = wd[15:8];
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 ready one clock", int'(req_ready), 0);
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) begin
            mem_arr[i] = DATA_W'(i * 16'h0101) ^ 16'hA5C3;
            shadow[i]  = DATA_W'(i * 16'h0101) ^ 16'hA5C3;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_bl_n} == 5'b11111, "R1 idle controls",
            int'({mem_ce_n, mem_oe_n, mem_we_n, mem_bl_n}), 5'h1f);
        chk(req_ready == 1'b0, "R1 ready low", int'(req_ready), 0);

        // directed corners
        txn(0, 26'h0000005, 16'h0, 2'b01, 0, 0, 0, 0, 0);      // R8 no setup, d=0
        txn(1, 26'h0000005, 16'h1234, 2'b01, 0, 2, 3, 9, 9);   // R6 low byte only
        txn(0, 26'h0000005, 16'h0, 2'b10, 0, 1, 1, 0, 0);      // R3 R6 readback
        txn(1, 26'h3FFFF07, 16'hBEEF, 2'b10, 1, 7, 7, 0, 0);   // R7 ext, R8 zero write set
        txn(0, 26'h3FFFF07, 16'h0, 2'b00, 1, 15, 4, 0, 0);     // R7 read ignores write set
        txn(1, 26'h0000009, 16'hC0DE, 2'b11, 1, 0, 0, 3, 5);   // R7 ext write timing
        txn(0, 26'h0000009, 16'h0, 2'b11, 0, 0, 255, 1, 1);    // R2 long data phase
        txn(1, 26'h000000A, 16'h5A5A, 2'b00, 0, 1, 2, 0, 0);   // R6 no lanes enabled
        txn(0, 26'h000000A, 16'h0, 2'b11, 0, 2, 1, 0, 0);

        for (int n = 0; n < 60; n++) begin
            txn($urandom_range(0, 1), ADDR_W'($urandom), DATA_W'($urandom),
                LANES'($urandom_range(0, 3)), $urandom_range(0, 1),
                $urandom_range(0, 15), $urandom_range(0, 12),
                $urandom_range(0, 15), $urandom_range(0, 12));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule